// File: doc/BRIEF.md
# Ping-Pong Hold Bank Controller

This block manages a two-bank hold stage for a row of display columns, one value per column in each bank. During every line, each column has one bank that captures new samples and one bank that drives the column output. A single bank-select input decides which bank does which. The block has no free-running toggle, so the system alternates the select level from one line to the next. When the select level stays the same across several lines, the columns keep showing the same held values.

Each line begins with a global discharge phase, and during it every column output is forced to zero. The bank select and a channel-order mode input are taken only on the first clock of that phase. When the phase ends, the columns present the bank that was filled during the previous line. Three digitized video channels come in, named A, B and C. Each group of three adjacent columns receives them in one of two rotations. One rotation suits striped pixel layouts. Alternating between the rotations line by line suits shifted (delta) layouts.

Top module: `pp_hold_bank_ctrl`

## Requirements
- R1: While the latched select is 1, a strobed column writes its routed sample into bank A, and its output shows bank B (when discharge is not active).
- R2: While the latched select is 0, a strobed column writes into bank B, and its output shows bank A (when discharge is not active).
- R3: When the select is latched at the same level at consecutive discharges, the outputs keep the same values across those discharges.
- R4: Discharge input high at a rising clock edge makes every column output zero from that edge until the first edge at which the input is sampled low.
- R5: After discharge ends, each output shows the value captured in its drive bank during the previous sampling pass.
- R6: The routed sample depends on column position p = index mod 3 (index counted from 0; columns 3n+1, 3n+2, 3n+3 with n from 0 to 79 in the default 240-column build). With mode 1, p = 0, 1, 2 take channels B, A, C. With mode 0, p = 0, 1, 2 take channels C, B, A.
- R7: Select and mode are latched only at an edge where discharge is high and was low at the previous edge. Changes at any other time have no effect until the next such edge.
- R8: A bank entry is written only at an edge where that column's strobe is high. A column whose strobe never fires during a line keeps its previous value.
- R9: Synchronous active-low reset clears both banks, the latched select, the latched mode and the discharge state, so every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bank_sel_i | input | 1 | Bank select, latched at discharge start |
| discharge_i | input | 1 | Discharge phase strobe |
| order_mode_i | input | 1 | Channel rotation mode, latched at discharge start |
| samp_stb_i | input | NUM_COLS | Per-column sampling strobes, bit i for column i |
| vid_a_i | input | DW | Video channel A sample |
| vid_b_i | input | DW | Video channel B sample |
| vid_c_i | input | DW | Video channel C sample |
| col_drive_o | output | NUM_COLS*DW | Column drive values, column i at bits [i*DW +: DW] |

## Verification
Lines are filled under two strobe patterns. One walks a single strobe across the columns, forward or in reverse. The other fires three adjacent strobes together. The first pattern shows that each column captures on its own strobe. The second shows that the three rotation lanes land on the correct columns at the same edge.

Lines with constant channel values A, B and C make the two rotations visible at fixed column positions. A line that skips one column tells a gated write apart from a bank-wide write. Discharges repeated at the same select level, together with select and mode changes made mid-line and mid-discharge, show that only the first discharge edge latches the controls.

// File: rtl/pp_hold_pkg.sv
// Package: shared constants, types and the lane rotation function for the
// ping-pong hold bank controller. Assumes three colour channels per group.
package pp_hold_pkg;

    localparam int unsigned LANES = 3;

    typedef enum logic [1:0] {
        SRC_A = 2'd0,
        SRC_B = 2'd1,
        SRC_C = 2'd2
    } src_e;

    // Channel feeding a lane (column index mod 3) under a given rotation mode.
    function automatic src_e lane_src(input logic mode, input int unsigned lane);
        src_e s;
        if (mode) begin
            case (lane)
                0:       s = SRC_B;
                1:       s = SRC_A;
                default: s = SRC_C;
            endcase
        end else begin
            case (lane)
                0:       s = SRC_C;
                1:       s = SRC_B;
                default: s = SRC_A;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/pp_ctrl_latch.sv
// Control latch: tracks the discharge phase and captures the bank select and
// the rotation mode on the first clock of each discharge phase only.
// Assumes discharge_i is synchronous to clk.
module pp_ctrl_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic discharge_i,
    input  logic bank_sel_i,
    input  logic order_mode_i,
    output logic dis_q_o,
    output logic cap_a_o,
    output logic mode_o
);

    logic dis_q;
    logic sel_q;
    logic mode_q;
    logic dis_start;

    // Discharge phase begins on a low-to-high transition of the strobe.
    always_comb dis_start = discharge_i & ~dis_q;

    // Register discharge state; latch select and mode at phase start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q  <= 1'b0;
            sel_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            dis_q <= discharge_i;
            if (dis_start) begin
                sel_q  <= bank_sel_i;
                mode_q <= order_mode_i;
            end
        end
    end

    assign dis_q_o = dis_q;
    assign cap_a_o = sel_q;
    assign mode_o  = mode_q;

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(discharge_i && !dis_q) |=> $stable(sel_q)); // R7
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(discharge_i && !dis_q) |=> $stable(mode_q)); // R7
    AST_SEL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (discharge_i && !dis_q) |=> (sel_q == $past(bank_sel_i))); // R7

endmodule

// File: rtl/pp_chan_router.sv
// Channel router: produces one sample per lane (column index mod 3) by
// rotating the three video channels according to the latched mode.
// Purely combinational; assumes the mode is stable within a line.
module pp_chan_router
    import pp_hold_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                       mode_i,
    input  logic [DW-1:0]              vid_a_i,
    input  logic [DW-1:0]              vid_b_i,
    input  logic [DW-1:0]              vid_c_i,
    output logic [LANES-1:0][DW-1:0]   lane_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Select the channel assigned to this lane under the current mode.
        always_comb begin
            case (lane_src(mode_i, l))
                SRC_A:   lane_o[l] = vid_a_i;
                SRC_B:   lane_o[l] = vid_b_i;
                SRC_C:   lane_o[l] = vid_c_i;
                default: lane_o[l] = vid_a_i;
            endcase
        end
    end

endmodule

// File: rtl/pp_col_cell.sv
// Column cell: two hold registers for one column. The latched select picks
// the capture bank; the other bank drives the output unless discharging.
// Assumes strobe and select are synchronous to clk.
module pp_col_cell #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_i,
    input  logic          cap_a_i,
    input  logic          dis_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] drive_o
);

    logic [DW-1:0] bank_a;
    logic [DW-1:0] bank_b;

    // Capture the routed sample into the selected bank on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_a <= '0;
            bank_b <= '0;
        end else if (stb_i) begin
            if (cap_a_i) bank_a <= din_i;
            else         bank_b <= din_i;
        end
    end

    // Drive the non-capturing bank, or ground during discharge.
    always_comb drive_o = dis_i ? '0 : (cap_a_i ? bank_b : bank_a);

    AST_KEEP_UNSTROBED: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> ($stable(bank_a) && $stable(bank_b))); // R8
    AST_B_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && cap_a_i) |=> $stable(bank_b)); // R1
    AST_A_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !cap_a_i) |=> $stable(bank_a)); // R2

endmodule

// File: rtl/pp_hold_bank_ctrl.sv
// Top: ping-pong hold bank controller for NUM_COLS columns of DW-bit samples.
// One control latch, one channel router and one cell per column.
// Assumes NUM_COLS is a multiple of three.
module pp_hold_bank_ctrl
    import pp_hold_pkg::*;
#(
    parameter int NUM_COLS = 240,
    parameter int DW       = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bank_sel_i,
    input  logic                   discharge_i,
    input  logic                   order_mode_i,
    input  logic [NUM_COLS-1:0]    samp_stb_i,
    input  logic [DW-1:0]          vid_a_i,
    input  logic [DW-1:0]          vid_b_i,
    input  logic [DW-1:0]          vid_c_i,
    output logic [NUM_COLS*DW-1:0] col_drive_o
);

    localparam int GROUPS = NUM_COLS / LANES;

    if (GROUPS * LANES != NUM_COLS) begin : g_bad_cols
        $error("NUM_COLS must be a multiple of three");
    end

    logic                     dis_q;
    logic                     cap_a;
    logic                     mode_q;
    logic [LANES-1:0][DW-1:0] lanes;

    pp_ctrl_latch u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .discharge_i  (discharge_i),
        .bank_sel_i   (bank_sel_i),
        .order_mode_i (order_mode_i),
        .dis_q_o      (dis_q),
        .cap_a_o      (cap_a),
        .mode_o       (mode_q)
    );

    pp_chan_router #(.DW(DW)) u_router (
        .mode_i  (mode_q),
        .vid_a_i (vid_a_i),
        .vid_b_i (vid_b_i),
        .vid_c_i (vid_c_i),
        .lane_o  (lanes)
    );

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        pp_col_cell #(.DW(DW)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .stb_i   (samp_stb_i[c]),
            .cap_a_i (cap_a),
            .dis_i   (dis_q),
            .din_i   (lanes[c % LANES]),
            .drive_o (col_drive_o[c*DW +: DW])
        );
    end

    AST_DIS_GROUND: assert property (@(posedge clk) disable iff (!rst_n)
        discharge_i |=> (col_drive_o == '0)); // R4
    AST_OUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis_q && !discharge_i) |=> $stable(col_drive_o)); // R3

endmodule

// File: tb/tb_pp_hold_bank_ctrl.sv
module tb_pp_hold_bank_ctrl;

    localparam int NC = 240;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bank_sel = 1'b0;
    logic              discharge = 1'b0;
    logic              mode = 1'b0;
    logic [NC-1:0]     stb = '0;
    logic [DW-1:0]     va = '0, vb = '0, vc = '0;
    logic [NC*DW-1:0]  drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state
    int ma[NC];
    int mb[NC];
    bit msel, mmode, mdis;

    always #5 clk = ~clk;

    pp_hold_bank_ctrl #(.NUM_COLS(NC), .DW(DW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_sel_i   (bank_sel),
        .discharge_i  (discharge),
        .order_mode_i (mode),
        .samp_stb_i   (stb),
        .vid_a_i      (va),
        .vid_b_i      (vb),
        .vid_c_i      (vc),
        .col_drive_o  (drive)
    );

    function automatic int pick(bit m, int p, int a, int b, int c);
        if (m) return (p == 0) ? b : (p == 1) ? a : c;
        else   return (p == 0) ? c : (p == 1) ? b : a;
    endfunction

    function automatic int exp_out(int c);
        if (mdis) return 0;
        return msel ? mb[c] : ma[c];
    endfunction

    function automatic int act_out(int c);
        return int'(drive[c*DW +: DW]);
    endfunction

    task automatic model_update();
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin ma[c] = 0; mb[c] = 0; end
            msel = 0; mmode = 0; mdis = 0;
        end else begin
            bit start;
            start = discharge && !mdis;
            for (int c = 0; c < NC; c++) begin
                if (stb[c]) begin
                    int v;
                    v = pick(mmode, c % 3, int'(va), int'(vb), int'(vc));
                    if (msel) ma[c] = v; else mb[c] = v;
                end
            end
            if (start) begin msel = bank_sel; mmode = mode; end
            mdis = discharge;
        end
    endtask

    task automatic compare_all();
        checks++;
        for (int c = 0; c < NC; c++) begin
            if (act_out(c) != exp_out(c)) begin
                errors++;
                $display("FAIL %s col %0d: actual %0h expected %0h",
                         !rst_n ? "R9" : mdis ? "R4" : msel ? "R1" : "R2",
                         c, act_out(c), exp_out(c));
                break;
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Discharge for len cycles; controls flipped after the first cycle (R7).
    task automatic do_discharge(bit sel, bit m, int len);
        discharge = 1'b1; bank_sel = sel; mode = m;
        step();
        chk("R4", act_out(0), 0);
        for (int i = 1; i < len; i++) begin
            bank_sel = ~sel; mode = ~m;
            step();
        end
        discharge = 1'b0;
        step();
    endtask

    // One sampling pass: single walking strobe or three adjacent strobes.
    task automatic run_line(bit triple, int skip, int a0, int b0, int c0,
                            int da, int db, int dc, bit wiggle, bit rev);
        int nsteps;
        nsteps = triple ? NC / 3 : NC;
        for (int k = 0; k < nsteps; k++) begin
            int idx;
            idx = rev ? (nsteps - 1 - k) : k;
            stb = '0;
            if (triple) begin
                for (int j = 0; j < 3; j++)
                    if (idx*3 + j != skip) stb[idx*3 + j] = 1'b1;
            end else if (idx != skip) begin
                stb[idx] = 1'b1;
            end
            va = DW'(a0 + k*da); vb = DW'(b0 + k*db); vc = DW'(c0 + k*dc);
            if (wiggle) begin bank_sel = k[0]; mode = k[1]; end
            step();
        end
        stb = '0;
        step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R9", act_out(0), 0);
        chk("R9", act_out(NC-1), 0);

        // Fill A under mode 1 with constant channels.
        do_discharge(1'b1, 1'b1, 3);
        run_line(1'b0, -1, 'h11, 'h22, 'h33, 0, 0, 0, 1'b1, 1'b0);
        do_discharge(1'b0, 1'b0, 2);
        chk("R6", act_out(0), 'h22);
        chk("R6", act_out(1), 'h11);
        chk("R6", act_out(2), 'h33);
        chk("R6", act_out(NC-1), 'h33);
        chk("R2", act_out(3), 'h22);

        // Fill B under mode 0.
        run_line(1'b1, -1, 'h44, 'h55, 'h66, 0, 0, 0, 1'b1, 1'b0);
        do_discharge(1'b1, 1'b1, 2);
        chk("R6", act_out(0), 'h66);
        chk("R6", act_out(1), 'h55);
        chk("R6", act_out(2), 'h44);
        chk("R1", act_out(NC-3), 'h66);

        // Same select again, no line between: held values persist.
        do_discharge(1'b1, 1'b0, 2);
        chk("R3", act_out(0), 'h66);
        chk("R3", act_out(1), 'h55);

        // Fill A under mode 0, skipping column 5.
        run_line(1'b0, 5, 'h77, 'h88, 'h99, 0, 0, 0, 1'b1, 1'b1);
        chk("R3", act_out(2), 'h44);
        do_discharge(1'b0, 1'b1, 2);
        chk("R5", act_out(3), 'h99);
        chk("R5", act_out(4), 'h88);
        chk("R8", act_out(5), 'h33);

        // Select change outside discharge is ignored.
        bank_sel = 1'b1; mode = 1'b0;
        step(); step();
        chk("R7", act_out(3), 'h99);
        chk("R7", act_out(5), 'h33);

        // Varied lines.
        for (int i = 0; i < 6; i++) begin
            do_discharge(i[0], i[1], 1 + i % 3);
            run_line(i[0] ^ i[2], (i == 3) ? 100 : -1, i*17, i*31 + 5, i*7 + 90,
                     3 + i, 5 + 2*i, 11, 1'b1, i[2]);
        end
        do_discharge(1'b0, 1'b0, 1);
        do_discharge(1'b1, 1'b0, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule